// File: doc/BRIEF.md
# Parallel Code-Memory Programming Controller

This block sits behind the parallel programming pins of an on-chip code store. It turns four mode pins and an active-low program strobe into byte writes, lock-bit writes, chip erase, verify reads and signature reads. The store itself is a register array inside the block. Write and erase cycles time themselves in clock counts, which are parameters. A `ready` output drops while a cycle is in progress. While a byte write is pending, a read of the byte being written returns a polling pattern.

Writes follow flash rules. A write can only clear bits: the new value is the AND of the stored byte and the write data. Only a chip erase returns bytes to FFh. Three lock bits raise the protection level step by step. With lock 1 set, byte writes are refused. With locks 1 and 2 set, verify reads are also blanked. With all three set, the fetch permission output for external execution goes low. The lock bits are never returned on the data output. A chip erase clears them.

The array holds 2^ADDR_W bytes. Reaching the full 8K store needs ADDR_W = 13. The default is smaller so that the array stays a modest register file.

Top module: `flashprog_ctrl`

## Requirements
- R1: The mode pins decode as {mode_pins[3],mode_pins[2],mode_pins[1],mode_pins[0]}: 0111 byte write, 0011 verify read, 1111 lock 1, 1100 lock 2, 1010 lock 3, 1000 chip erase, 0000 signature read. A strobe falling edge under any other code does nothing, and `ready` stays 1.
- R2: The reset input is asynchronous and active low, and its release is synchronised over two clocks. After reset, `ready`=1, `rd_vld`=0, all lock bits are clear and `ext_fetch_ok`=1.
- R3: A falling edge of `prog_n` while idle, with the byte-write code, starts a write. `ready` is 0 for exactly WRITE_CYC cycles, starting at the edge that samples the strobe low. The byte is committed at the last of those edges.
- R4: A byte write stores (old AND data). Writing 0Fh over F3h leaves 03h.
- R5: While a byte write is pending, a verify read of its address returns the write data with bit 7 inverted. Once the write is done, the read returns the true byte.
- R6: A chip erase takes effect only if `prog_n` is sampled low on ERASE_CYC consecutive edges. It sets every byte to FFh and clears all lock bits. A shorter strobe aborts the erase and changes nothing.
- R7: With lock 1 set, a byte-write strobe is ignored. `ready` stays 1 and the stored byte is unchanged. Verify reads still work.
- R8: With locks 1 and 2 set, verify reads return 00h.
- R9: `ext_fetch_ok` is 0 exactly when all three lock bits are set.
- R10: A signature read returns 1Eh at address 030h, 52h at 031h, and at 032h FFh (HIGH_VOLT=1) or 05h (HIGH_VOLT=0). Any other address returns 00h.
- R11: While `ready` is 0, strobes, mode changes and reads are ignored. The one exception is a data-polling read of the address being written. An ignored read gives `rd_vld`=0.
- R12: A read is taken when `rd_en` is sampled high with the verify-read or signature code. `rd_vld` pulses high with `rdata` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pins | input | 4 | Operation select code |
| prog_n | input | 1 | Active-low program strobe |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rd_vld | output | 1 | Read data valid pulse |
| ready | output | 1 | High when idle, low during a write or erase |
| ext_fetch_ok | output | 1 | External execution permitted |

## Verification
A behavioural model, updated on each clock, is compared with every output on every cycle. Directed checks aim at these corner cases:
- A write cycle one clock too short or too long shows up as the wrong count of `ready`-low cycles.
- A write that overwrites instead of ANDing leaves 0Fh instead of 03h.
- A polling read that inverts the wrong bit returns something other than DAh for a 5Ah write. So does one that returns stale array data.
- An erase strobe one sample short must leave the lock level intact. A design that counts wrongly clears the locks early.
- A lock-1 strobe during a busy write must not land. If it did, a later write would be refused.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_WRITE, OP_READ, OP_LOCK1, OP_LOCK2, OP_LOCK3, OP_ERASE, OP_SIG
  } fp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_PROG, ST_ERASE
  } fp_state_e;

  localparam logic [3:0] CODE_WRITE = 4'b0111;
  localparam logic [3:0] CODE_READ  = 4'b0011;
  localparam logic [3:0] CODE_LOCK1 = 4'b1111;
  localparam logic [3:0] CODE_LOCK2 = 4'b1100;
  localparam logic [3:0] CODE_LOCK3 = 4'b1010;
  localparam logic [3:0] CODE_ERASE = 4'b1000;
  localparam logic [3:0] CODE_SIG   = 4'b0000;

  localparam logic [7:0] SIG_ADDR0 = 8'h30;
  localparam logic [7:0] SIG_MAKER = 8'h1E;
  localparam logic [7:0] SIG_PART  = 8'h52;
  localparam logic [7:0] SIG_HV    = 8'hFF;
  localparam logic [7:0] SIG_LV    = 8'h05;

endpackage

// File: rtl/flashprog_decode.sv
module flashprog_decode
  import flashprog_pkg::*;
(
  input  logic [3:0] mode_pins,
  output fp_op_e     op
);

  always_comb begin
    unique case (mode_pins)
      CODE_WRITE: op = OP_WRITE;
      CODE_READ:  op = OP_READ;
      CODE_LOCK1: op = OP_LOCK1;
      CODE_LOCK2: op = OP_LOCK2;
      CODE_LOCK3: op = OP_LOCK3;
      CODE_ERASE: op = OP_ERASE;
      CODE_SIG:   op = OP_SIG;
      default:    op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/flashprog_seq.sv
module flashprog_seq
  import flashprog_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WRITE_CYC = 40,
  parameter int ERASE_CYC = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fp_op_e            op,
  input  logic              prog_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              ready,
  output logic              poll_on,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [7:0]        lat_data,
  output logic              commit_wr,
  output logic              erase_go,
  output logic [2:0]        lock
);

  localparam int MAXC  = (WRITE_CYC > ERASE_CYC) ? WRITE_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WRITE_CYC - 1);
  localparam logic [CNT_W-1:0] ER_LAST = CNT_W'(ERASE_CYC - 1);

  fp_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  fp_op_e            lop_q, lop_d;
  logic [ADDR_W-1:0] la_q, la_d;
  logic [7:0]        ld_q, ld_d;
  logic [2:0]        lock_q, lock_d;
  logic              strobe_q;
  logic              fall;
  logic              start_prog, start_erase, prog_done;

  assign fall        = strobe_q & ~prog_n;
  assign start_prog  = (state_q == ST_IDLE) && fall &&
                       ((op == OP_WRITE && !lock_q[0]) || op == OP_LOCK1 ||
                        op == OP_LOCK2 || op == OP_LOCK3);
  assign start_erase = (state_q == ST_IDLE) && fall && (op == OP_ERASE);
  assign prog_done   = (state_q == ST_PROG) && (cnt_q == WR_LAST);
  assign commit_wr   = prog_done && (lop_q == OP_WRITE);
  assign erase_go    = (state_q == ST_ERASE) && !prog_n && (cnt_q == ER_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lop_d   = lop_q;
    la_d    = la_q;
    ld_d    = ld_q;
    lock_d  = lock_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_prog) begin
          state_d = ST_PROG;
          cnt_d   = '0;
          lop_d   = op;
          la_d    = addr;
          ld_d    = wdata;
        end else if (start_erase) begin
          state_d = ST_ERASE;
          cnt_d   = CNT_W'(1);
        end
      end
      ST_PROG: begin
        if (prog_done) begin
          state_d = ST_IDLE;
          unique case (lop_q)
            OP_LOCK1: lock_d[0] = 1'b1;
            OP_LOCK2: lock_d[1] = 1'b1;
            OP_LOCK3: lock_d[2] = 1'b1;
            default:  lock_d    = lock_q;
          endcase
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ERASE: begin
        if (prog_n) begin
          state_d = ST_IDLE;
        end else if (erase_go) begin
          state_d = ST_IDLE;
          lock_d  = 3'b000;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      lop_q    <= OP_NONE;
      la_q     <= '0;
      ld_q     <= '0;
      lock_q   <= 3'b000;
      strobe_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      lop_q    <= lop_d;
      la_q     <= la_d;
      ld_q     <= ld_d;
      lock_q   <= lock_d;
      strobe_q <= prog_n;
    end
  end

  assign ready    = (state_q == ST_IDLE);
  assign poll_on  = (state_q == ST_PROG) && (lop_q == OP_WRITE);
  assign lat_addr = la_q;
  assign lat_data = ld_q;
  assign lock     = lock_q;

  // R3: a program cycle never runs past its budget
  p_prog_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG) |-> (cnt_q <= WR_LAST));

  // R3: the controller returns to ready right after a commit
  p_commit_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |=> ready);

  // R7: lock bits only accumulate, except through an erase
  p_lock_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_go |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R6: an erase fires only under a strobe that is still held low
  p_erase_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (!prog_n && $past(!prog_n)));

endmodule

// File: rtl/flashprog_array.sv
module flashprog_array
  import flashprog_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter bit HIGH_VOLT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fp_op_e            op,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic              poll_on,
  input  logic [ADDR_W-1:0] lat_addr,
  input  logic [7:0]        lat_data,
  input  logic              commit_wr,
  input  logic              erase_go,
  input  logic [2:0]        lock,
  output logic [7:0]        rdata,
  output logic              rd_vld
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [7:0] SIG_LAST = HIGH_VOLT ? SIG_HV : SIG_LV;

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q, rdata_d;
  logic       vld_q, vld_d;
  logic [7:0] sig_val;
  logic       rd_req;

  always_ff @(posedge clk) begin
    if (erase_go) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit_wr) begin
      mem[lat_addr] <= mem[lat_addr] & lat_data;
    end
  end

  always_comb begin
    if      (addr == ADDR_W'(SIG_ADDR0))     sig_val = SIG_MAKER;
    else if (addr == ADDR_W'(SIG_ADDR0 + 1)) sig_val = SIG_PART;
    else if (addr == ADDR_W'(SIG_ADDR0 + 2)) sig_val = SIG_LAST;
    else                                     sig_val = 8'h00;
  end

  assign rd_req = rd_en && (op == OP_READ || op == OP_SIG);

  always_comb begin
    rdata_d = rdata_q;
    vld_d   = 1'b0;
    if (rd_req) begin
      if (busy) begin
        if (poll_on && op == OP_READ && addr == lat_addr) begin
          vld_d   = 1'b1;
          rdata_d = {~lat_data[7], lat_data[6:0]};
        end
      end else if (op == OP_SIG) begin
        vld_d   = 1'b1;
        rdata_d = sig_val;
      end else begin
        vld_d   = 1'b1;
        rdata_d = (lock[0] && lock[1]) ? 8'h00 : mem[addr];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 8'h00;
      vld_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      vld_q   <= vld_d;
    end
  end

  assign rdata  = rdata_q;
  assign rd_vld = vld_q;

  // R12: valid data follows a request by one cycle
  p_vld_follows_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(rd_en));

  // R11: during busy the only answered read is the polling one
  p_busy_read_poll_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(busy)) |-> $past(poll_on && addr == lat_addr));

endmodule

// File: rtl/flashprog_ctrl.sv
module flashprog_ctrl
  import flashprog_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int WRITE_CYC = 40,
  parameter int ERASE_CYC = 60,
  parameter bit HIGH_VOLT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_pins,
  input  logic              prog_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rd_vld,
  output logic              ready,
  output logic              ext_fetch_ok
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  fp_op_e            op;
  logic              poll_on, commit_wr, erase_go;
  logic [ADDR_W-1:0] lat_addr;
  logic [7:0]        lat_data;
  logic [2:0]        lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  flashprog_decode u_dec (
    .mode_pins (mode_pins),
    .op        (op)
  );

  flashprog_seq #(
    .ADDR_W    (ADDR_W),
    .WRITE_CYC (WRITE_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op        (op),
    .prog_n    (prog_n),
    .addr      (addr),
    .wdata     (wdata),
    .ready     (ready),
    .poll_on   (poll_on),
    .lat_addr  (lat_addr),
    .lat_data  (lat_data),
    .commit_wr (commit_wr),
    .erase_go  (erase_go),
    .lock      (lock)
  );

  flashprog_array #(
    .ADDR_W    (ADDR_W),
    .HIGH_VOLT (HIGH_VOLT)
  ) u_arr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .op        (op),
    .rd_en     (rd_en),
    .addr      (addr),
    .busy      (~ready),
    .poll_on   (poll_on),
    .lat_addr  (lat_addr),
    .lat_data  (lat_data),
    .commit_wr (commit_wr),
    .erase_go  (erase_go),
    .lock      (lock),
    .rdata     (rdata),
    .rd_vld    (rd_vld)
  );

  assign ext_fetch_ok = ~(&lock);

  // R9: fetch permission only drops after the third lock is programmed
  p_fetch_drop_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(ext_fetch_ok) |-> $past(!ready));

endmodule

// File: tb/flashprog_ctrl_test.sv
module flashprog_ctrl_test;

  localparam int AW  = 10;
  localparam int WC  = 40;
  localparam int EC  = 60;
  localparam int DEP = 1 << AW;

  localparam logic [3:0] M_WR = 4'b0111, M_RD = 4'b0011, M_L1 = 4'b1111,
                         M_L2 = 4'b1100, M_L3 = 4'b1010, M_ER = 4'b1000,
                         M_SG = 4'b0000, M_BAD = 4'b0101;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    mode_pins;
  logic          prog_n, rd_en;
  logic [AW-1:0] addr;
  logic [7:0]    wdata, rdata;
  logic          rd_vld, ready, ext_fetch_ok;

  int checks = 0, failures = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  flashprog_ctrl #(.ADDR_W(AW), .WRITE_CYC(WC), .ERASE_CYC(EC), .HIGH_VOLT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .prog_n(prog_n),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rd_vld(rd_vld), .ready(ready), .ext_fetch_ok(ext_fetch_ok)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [DEP];
  int         m_st, m_cnt, m_lop, m_la;
  logic [7:0] m_ld, m_rd;
  logic [2:0] m_lock;
  bit         m_pq, m_vld;

  function automatic int op_of(input logic [3:0] m);
    case (m)
      M_WR: return 1;  M_RD: return 2;  M_L1: return 3;  M_L2: return 4;
      M_L3: return 5;  M_ER: return 6;  M_SG: return 7;  default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_lop = 0; m_la = 0; m_ld = 0;
      m_lock = 3'b000; m_pq = 1'b1; m_vld = 1'b0; m_rd = 8'h00;
    end else begin
      int  op;
      bit  fall;
      op   = op_of(mode_pins);
      fall = m_pq && !prog_n;
      m_vld = 1'b0;
      if (rd_en && (op == 2 || op == 7)) begin
        if (m_st != 0) begin
          if (m_st == 1 && m_lop == 1 && op == 2 && int'(addr) == m_la) begin
            m_vld = 1'b1; m_rd = m_ld ^ 8'h80;
          end
        end else if (op == 7) begin
          m_vld = 1'b1;
          m_rd = (addr == 'h30) ? 8'h1E : (addr == 'h31) ? 8'h52 :
                 (addr == 'h32) ? 8'hFF : 8'h00;
        end else begin
          m_vld = 1'b1;
          m_rd = (m_lock[0] && m_lock[1]) ? 8'h00 : m_mem[addr];
        end
      end
      if (m_st == 0) begin
        if (fall && ((op == 1 && !m_lock[0]) || (op >= 3 && op <= 5))) begin
          m_st = 1; m_cnt = 0; m_lop = op; m_la = int'(addr); m_ld = wdata;
        end else if (fall && op == 6) begin
          m_st = 2; m_cnt = 1;
        end
      end else if (m_st == 1) begin
        if (m_cnt == WC - 1) begin
          if (m_lop == 1) m_mem[m_la] = m_mem[m_la] & m_ld;
          if (m_lop >= 3) m_lock[m_lop-3] = 1'b1;
          m_st = 0;
        end else m_cnt++;
      end else begin
        if (prog_n) m_st = 0;
        else if (m_cnt == EC - 1) begin
          for (int i = 0; i < DEP; i++) m_mem[i] = 8'hFF;
          m_lock = 3'b000; m_st = 0;
        end else m_cnt++;
      end
      m_pq = prog_n;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(ready === (m_st == 0), "R3 ready vs model", ready, m_st == 0);
      chk(rd_vld === m_vld, "R12 rd_vld vs model", rd_vld, m_vld);
      if (m_vld) chk(rdata === m_rd, "R12 rdata vs model", rdata, m_rd);
      chk(ext_fetch_ok === !(&m_lock), "R9 ext_fetch_ok vs model", ext_fetch_ok, !(&m_lock));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic strobe(input logic [3:0] m, input int a, input logic [7:0] d, input int lowc);
    @(negedge clk);
    mode_pins = m; addr = AW'(a); wdata = d; prog_n = 1'b0;
    repeat (lowc) @(negedge clk);
    prog_n = 1'b1;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (!ready && g < 1000) begin @(negedge clk); g++; end
  endtask

  task automatic rd(input logic [3:0] m, input int a, output logic [7:0] v, output logic vl);
    @(negedge clk);
    mode_pins = m; addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata; vl = rd_vld;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       vl;
    int         n;
    rst_n = 1'b0; mode_pins = M_SG; prog_n = 1'b1; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;
    // R2 reset state
    chk(ready === 1'b1, "R2 ready after reset", ready, 1);
    chk(rd_vld === 1'b0, "R2 rd_vld after reset", rd_vld, 0);
    chk(ext_fetch_ok === 1'b1, "R2 fetch after reset", ext_fetch_ok, 1);

    // R6 full erase initialises the array
    strobe(M_ER, 0, 8'h00, EC); wait_idle();
    rd(M_RD, 5, v, vl);
    chk(vl && v == 8'hFF, "R6 erased byte", v, 8'hFF);

    // R3 write duration
    strobe(M_WR, 10, 8'h5A, 1);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
    chk(n == WC, "R3 busy cycles", n, WC);
    rd(M_RD, 10, v, vl);
    chk(vl && v == 8'h5A, "R3 committed byte", v, 8'h5A);

    // R5 data polling, R11 other reads ignored while busy
    strobe(M_WR, 12, 8'h5A, 1);
    rd(M_RD, 12, v, vl);
    chk(vl && v == 8'hDA, "R5 polling value", v, 8'hDA);
    rd(M_RD, 13, v, vl);
    chk(vl == 1'b0, "R11 non-poll read during busy", vl, 0);
    wait_idle();
    rd(M_RD, 12, v, vl);
    chk(vl && v == 8'h5A, "R5 true data after write", v, 8'h5A);

    // R4 AND semantics on a non-blank byte
    strobe(M_WR, 20, 8'hF3, 1); wait_idle();
    strobe(M_WR, 20, 8'h0F, 1); wait_idle();
    rd(M_RD, 20, v, vl);
    chk(vl && v == 8'h03, "R4 AND on rewrite", v, 8'h03);

    // R11 lock-1 strobe during a busy write is ignored
    strobe(M_WR, 40, 8'h11, 1);
    repeat (3) @(negedge clk);
    strobe(M_L1, 0, 8'h00, 1);
    wait_idle();
    strobe(M_WR, 41, 8'h22, 1);
    chk(ready === 1'b0, "R11 later write accepted", ready, 0);
    wait_idle();
    rd(M_RD, 41, v, vl);
    chk(vl && v == 8'h22, "R11 later write landed", v, 8'h22);

    // R10 signature
    rd(M_SG, 'h30, v, vl); chk(vl && v == 8'h1E, "R10 sig 030h", v, 8'h1E);
    rd(M_SG, 'h31, v, vl); chk(vl && v == 8'h52, "R10 sig 031h", v, 8'h52);
    rd(M_SG, 'h32, v, vl); chk(vl && v == 8'hFF, "R10 sig 032h", v, 8'hFF);
    rd(M_SG, 'h33, v, vl); chk(vl && v == 8'h00, "R10 sig other", v, 8'h00);

    // R1 undefined code does nothing
    strobe(M_BAD, 10, 8'h00, 1);
    chk(ready === 1'b1, "R1 undefined code", ready, 1);

    // R7 lock 1 blocks writes, verify still works
    strobe(M_L1, 0, 8'h00, 1); wait_idle();
    strobe(M_WR, 10, 8'h00, 1);
    chk(ready === 1'b1, "R7 write refused", ready, 1);
    rd(M_RD, 10, v, vl);
    chk(vl && v == 8'h5A, "R7 byte unchanged", v, 8'h5A);

    // R8 lock 2 blanks verify
    strobe(M_L2, 0, 8'h00, 1); wait_idle();
    rd(M_RD, 10, v, vl);
    chk(vl && v == 8'h00, "R8 blanked verify", v, 8'h00);
    chk(ext_fetch_ok === 1'b1, "R9 fetch at level 3", ext_fetch_ok, 1);

    // R9 lock 3 drops fetch permission
    strobe(M_L3, 0, 8'h00, 1); wait_idle();
    chk(ext_fetch_ok === 1'b0, "R9 fetch at level 4", ext_fetch_ok, 0);

    // R6 short erase aborts, full erase clears
    strobe(M_ER, 0, 8'h00, EC - 1); wait_idle();
    chk(ext_fetch_ok === 1'b0, "R6 short erase keeps locks", ext_fetch_ok, 0);
    strobe(M_ER, 0, 8'h00, EC); wait_idle();
    chk(ext_fetch_ok === 1'b1, "R6 erase clears locks", ext_fetch_ok, 1);
    rd(M_RD, 10, v, vl);
    chk(vl && v == 8'hFF, "R6 erase fills FF", v, 8'hFF);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule